// File: doc/BRIEF.md
# Resonant Converter Mode Controller

This block is the digital core of a primary-side controller for a resonant forward converter. It drives the gate of the primary switch and decides, one converter cycle at a time, how long the switch conducts and how long it rests. After each on-pulse it measures the rest time, from the falling edge of the gate to the resonance edge reported by a collector-sense comparator. It then derives the next on-time as three quarters of that measurement.

Five operating modes share this timing engine. Standby trims the on-time first and then stretches the rest time as the load falls. Normal runs the plain resonant cycle. Overload lets a peak-current flag end each pulse early. Foldback halves the on-time, adds a fixed rest extension and counts a fixed number of cycles. Power Burst then runs a set number of full-power cycles before deciding between Normal and Foldback.

The power sequencer gates the whole block with an enable. It also pulses an init strobe on entry to its start-up state, which puts the controller back in Standby. Mode decisions are taken only at the end of an on-pulse, using the comparator flags present at that moment. The block has no streaming data path. All pins are plain control levels or single-cycle pulses.

Top module: `resconv_mode_ctrl`

## Requirements
- R1: While `en_i` is low, `gate_o` is low one cycle later, `mode_o` reads Standby (0), and the stored rest measurement returns to `OFF_INIT`. After `en_i` rises, the first on-pulse therefore lasts floor(3*OFF_INIT/4) cycles.
- R2: The rest measurement is the number of gate-low cycles from the gate falling up to and including the cycle in which `res_edge_i` is high. If no edge arrives, the measurement caps at `OFF_MAX`. A `res_edge_i` pulse while the gate is high has no effect.
- R3: In Normal, Overload (uncut) and Power Burst, the on-pulse lasts floor(3*M/4) cycles, where M is the latest rest measurement. The on-time never drops below 1 cycle.
- R4: Mode codes on `mode_o` are: Standby = 0, Normal = 1, Overload = 2, Foldback = 3, Power Burst = 4. At the end of a Normal pulse, `high_i` moves the block to Overload; otherwise `low_i` moves it to Standby; otherwise it stays in Normal. Outside init and enable, the mode changes only at the end of an on-pulse.
- R5: Standby keeps a level from 0 to `LVL_MAX`. At each pulse end, `low_i` raises the level (saturating) and its absence lowers it. With `low_i` low at level 0, the block moves to Normal.
- R6: In Standby, the on-time is the Normal on-time shifted right by min(level, `CUT_STEPS`). When the level exceeds `CUT_STEPS`, the rest time is extended by (level - `CUT_STEPS`) << `WAIT_SHIFT` cycles.
- R7: In Overload, Foldback and Power Burst, `peak_i` ends the on-pulse in the cycle it is seen, so the gate is high for that cycle and falls after it. In Standby and Normal, `peak_i` has no effect.
- R8: At the end of an Overload pulse, the block moves to Foldback if the pulse was cut by `peak_i` and was shorter than `ON_MIN` cycles. It moves to Normal if the pulse was not cut and `high_i` is low. Otherwise it stays in Overload.
- R9: Foldback uses half the Normal on-time and extends every rest time by `FB_WAIT` cycles. After `FB_CYCLES` pulses it moves to Power Burst.
- R10: Power Burst runs `BURST_CYCLES` full-length pulses. At the end of the last one, the block goes to Foldback if `high_i` is set and to Normal otherwise.
- R11: A cycle with `init_i` high sets Standby at level 0 on the next clock. Switching goes on without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| en_i | input | 1 | Run enable from the power sequencer |
| init_i | input | 1 | Start-up strobe, forces Standby |
| res_edge_i | input | 1 | Single-cycle resonance-edge pulse from collector sensing |
| low_i | input | 1 | Switch current below the light-load threshold |
| high_i | input | 1 | Switch current above the overload threshold |
| peak_i | input | 1 | Switch current above the peak limit |
| gate_o | output | 1 | Primary switch drive, high while conducting |
| mode_o | output | 3 | Current operating mode code |

## Verification
The assertions assume that `res_edge_i` and `init_i` are single-cycle pulses. They also assume that the current flags are synchronous to `clk` and change only between clock edges. The bench drives every input on the falling clock edge, raises `res_edge_i` for exactly one cycle, and sets `low_i` and `high_i` during the rest phase so that they are steady when the pulse ends. It holds `peak_i` from a chosen on-cycle until the gate falls, and it applies the init strobe and the enable drop only after the pulse-by-pulse scoreboard has drained.

// File: rtl/resconv_pkg.sv
package resconv_pkg;
  typedef enum logic [2:0] {
    MD_STANDBY  = 3'd0,
    MD_NORMAL   = 3'd1,
    MD_OVERLOAD = 3'd2,
    MD_FOLDBACK = 3'd3,
    MD_BURST    = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ON,
    PH_OFF,
    PH_WAIT
  } phase_e;
endpackage

// File: rtl/resconv_off_timer.sv
module resconv_off_timer #(
  parameter int CNT_W    = 10,
  parameter int OFF_MAX  = 200,
  parameter int OFF_INIT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             active_i,
  input  logic             edge_i,
  output logic             done_o,
  output logic [CNT_W-1:0] meas_o
);
  localparam logic [CNT_W-1:0] MAX_V  = CNT_W'(OFF_MAX);
  localparam logic [CNT_W-1:0] INIT_V = CNT_W'(OFF_INIT);

  logic [CNT_W-1:0] cnt;

  // window closes on the resonance edge or on the timeout
  assign done_o = active_i && (edge_i || (cnt == MAX_V - 1'b1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      cnt    <= '0;
      meas_o <= INIT_V;
    end else if (active_i) begin
      if (done_o) begin
        cnt    <= '0;
        meas_o <= cnt + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  // R2: measurement stays inside 1..OFF_MAX
  p_meas_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_o != '0) && (meas_o <= MAX_V));

  // R2: edges outside the rest window leave the measurement alone
  p_edge_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !active_i) |=> $stable(meas_o));
endmodule

// File: rtl/resconv_on_calc.sv
module resconv_on_calc
  import resconv_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int LVL_W      = 3,
  parameter int CUT_STEPS  = 2,
  parameter int WAIT_SHIFT = 3,
  parameter int FB_WAIT    = 20
) (
  input  logic [CNT_W-1:0] meas_i,
  input  mode_e            mode_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [CNT_W-1:0] on_tgt_o,
  output logic [CNT_W-1:0] extra_o,
  output logic             cut_en_o
);
  localparam logic [LVL_W-1:0] CUT_V = LVL_W'(CUT_STEPS);

  logic [CNT_W+1:0] triple;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] raw;
  logic [LVL_W-1:0] shamt;

  always_comb begin
    // 3*M by shift-and-add, then divide by four
    triple  = {2'b00, meas_i} + {1'b0, meas_i, 1'b0};
    base    = triple[CNT_W+1:2];
    shamt   = (lvl_i > CUT_V) ? CUT_V : lvl_i;
    raw     = base;
    extra_o = '0;
    case (mode_i)
      MD_STANDBY: begin
        raw = base >> shamt;
        if (lvl_i > CUT_V) extra_o = CNT_W'(lvl_i - CUT_V) << WAIT_SHIFT;
      end
      MD_FOLDBACK: begin
        raw     = base >> 1;
        extra_o = CNT_W'(FB_WAIT);
      end
      default: raw = base;
    endcase
    on_tgt_o = (raw == '0) ? CNT_W'(1) : raw;
  end

  assign cut_en_o = (mode_i == MD_OVERLOAD) || (mode_i == MD_FOLDBACK) ||
                    (mode_i == MD_BURST);
endmodule

// File: rtl/resconv_mode_fsm.sv
module resconv_mode_fsm
  import resconv_pkg::*;
#(
  parameter int CNT_W        = 10,
  parameter int LVL_MAX      = 4,
  parameter int LVL_W        = 3,
  parameter int ON_MIN       = 12,
  parameter int FB_CYCLES    = 4,
  parameter int BURST_CYCLES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             init_i,
  input  logic             end_i,
  input  logic             cut_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             low_i,
  input  logic             high_i,
  output mode_e            mode_o,
  output logic [LVL_W-1:0] lvl_o
);
  localparam int CYC_MAX = (FB_CYCLES > BURST_CYCLES) ? FB_CYCLES : BURST_CYCLES;
  localparam int CYC_W   = $clog2(CYC_MAX + 1);
  localparam logic [CYC_W-1:0] FB_LAST = CYC_W'(FB_CYCLES - 1);
  localparam logic [CYC_W-1:0] BU_LAST = CYC_W'(BURST_CYCLES - 1);
  localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(LVL_MAX);
  localparam logic [CNT_W-1:0] MIN_V   = CNT_W'(ON_MIN);

  logic [CYC_W-1:0] cyc;

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i || init_i) begin
      mode_o <= MD_STANDBY;
      lvl_o  <= '0;
      cyc    <= '0;
    end else if (end_i) begin
      case (mode_o)
        MD_STANDBY: begin
          if (low_i) begin
            if (lvl_o != LVL_TOP) lvl_o <= lvl_o + 1'b1;
          end else if (lvl_o == '0) begin
            mode_o <= MD_NORMAL;
          end else begin
            lvl_o <= lvl_o - 1'b1;
          end
        end
        MD_NORMAL: begin
          if (high_i) begin
            mode_o <= MD_OVERLOAD;
          end else if (low_i) begin
            mode_o <= MD_STANDBY;
            lvl_o  <= '0;
          end
        end
        MD_OVERLOAD: begin
          if (cut_i && (len_i < MIN_V)) begin
            mode_o <= MD_FOLDBACK;
            cyc    <= '0;
          end else if (!cut_i && !high_i) begin
            mode_o <= MD_NORMAL;
          end
        end
        MD_FOLDBACK: begin
          if (cyc == FB_LAST) begin
            mode_o <= MD_BURST;
            cyc    <= '0;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        MD_BURST: begin
          if (cyc == BU_LAST) begin
            mode_o <= high_i ? MD_FOLDBACK : MD_NORMAL;
            cyc    <= '0;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        default: mode_o <= MD_STANDBY;
      endcase
    end
  end

  // R11: the strobe lands in Standby at level zero
  p_init_standby_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && init_i) |=> (mode_o == MD_STANDBY) && (lvl_o == '0));

  // R4: no mode change between pulse ends
  p_hold_between_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !init_i && !end_i) |=> $stable(mode_o));

  // R4: overload flag at a Normal pulse end
  p_normal_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !init_i && end_i && (mode_o == MD_NORMAL) && high_i) |=>
      (mode_o == MD_OVERLOAD));

  // R5: level saturates
  p_lvl_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_o <= LVL_TOP);
endmodule

// File: rtl/resconv_mode_ctrl.sv
module resconv_mode_ctrl
  import resconv_pkg::*;
#(
  parameter int CNT_W        = 10,
  parameter int OFF_MAX      = 200,
  parameter int OFF_INIT     = 64,
  parameter int ON_MIN       = 12,
  parameter int FB_CYCLES    = 4,
  parameter int BURST_CYCLES = 3,
  parameter int FB_WAIT      = 20,
  parameter int CUT_STEPS    = 2,
  parameter int LVL_MAX      = 4,
  parameter int WAIT_SHIFT   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       init_i,
  input  logic       res_edge_i,
  input  logic       low_i,
  input  logic       high_i,
  input  logic       peak_i,
  output logic       gate_o,
  output logic [2:0] mode_o
);
  localparam int LVL_W = $clog2(LVL_MAX + 1);

  phase_e           phase;
  logic [CNT_W-1:0] seq_cnt;
  logic [CNT_W:0]   seq_nxt;
  logic [CNT_W-1:0] meas;
  logic [CNT_W-1:0] on_tgt;
  logic [CNT_W-1:0] extra;
  mode_e            mode;
  logic [LVL_W-1:0] lvl;
  logic             cut_en;
  logic             cut_hit;
  logic             on_end;
  logic             off_done;
  logic             wait_end;

  assign seq_nxt  = {1'b0, seq_cnt} + 1'b1;
  assign cut_hit  = (phase == PH_ON) && peak_i && cut_en;
  assign on_end   = (phase == PH_ON) && ((seq_nxt >= {1'b0, on_tgt}) || cut_hit);
  assign wait_end = seq_nxt >= {1'b0, extra};

  resconv_off_timer #(
    .CNT_W(CNT_W), .OFF_MAX(OFF_MAX), .OFF_INIT(OFF_INIT)
  ) u_off (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .active_i(phase == PH_OFF), .edge_i(res_edge_i),
    .done_o(off_done), .meas_o(meas)
  );

  resconv_on_calc #(
    .CNT_W(CNT_W), .LVL_W(LVL_W), .CUT_STEPS(CUT_STEPS),
    .WAIT_SHIFT(WAIT_SHIFT), .FB_WAIT(FB_WAIT)
  ) u_calc (
    .meas_i(meas), .mode_i(mode), .lvl_i(lvl),
    .on_tgt_o(on_tgt), .extra_o(extra), .cut_en_o(cut_en)
  );

  resconv_mode_fsm #(
    .CNT_W(CNT_W), .LVL_MAX(LVL_MAX), .LVL_W(LVL_W), .ON_MIN(ON_MIN),
    .FB_CYCLES(FB_CYCLES), .BURST_CYCLES(BURST_CYCLES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .init_i(init_i),
    .end_i(on_end), .cut_i(cut_hit), .len_i(seq_nxt[CNT_W-1:0]),
    .low_i(low_i), .high_i(high_i), .mode_o(mode), .lvl_o(lvl)
  );

  // converter cycle sequencer: on, measured rest, optional extended rest
  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      phase   <= PH_IDLE;
      seq_cnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase   <= PH_ON;
          seq_cnt <= '0;
        end
        PH_ON: begin
          if (on_end) begin
            phase   <= PH_OFF;
            seq_cnt <= '0;
          end else begin
            seq_cnt <= seq_cnt + 1'b1;
          end
        end
        PH_OFF: begin
          seq_cnt <= '0;
          if (off_done) phase <= (extra != '0) ? PH_WAIT : PH_ON;
        end
        default: begin
          if (wait_end) begin
            phase   <= PH_ON;
            seq_cnt <= '0;
          end else begin
            seq_cnt <= seq_cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign gate_o = (phase == PH_ON);
  assign mode_o = mode;

  // R1: disabled controller releases the switch and shows Standby
  p_gate_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!gate_o && (mode_o == 3'd0)));

  // R3: on counter never passes the target
  p_on_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ON) |-> (seq_cnt < on_tgt));

  // R7: a peak in a protective mode drops the gate next cycle
  p_peak_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cut_hit |=> !gate_o);
endmodule

// File: tb/test_resconv_mode_ctrl.sv
`timescale 1ns/1ps
module test_resconv_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0, init_i = 1'b0, res_edge_i = 1'b0;
  logic low_i = 1'b0, high_i = 1'b0, peak_i = 1'b0;
  logic gate_o;
  logic [2:0] mode_o;

  always #2 clk = ~clk;

  resconv_mode_ctrl i_resconv_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .init_i(init_i),
    .res_edge_i(res_edge_i), .low_i(low_i), .high_i(high_i), .peak_i(peak_i),
    .gate_o(gate_o), .mode_o(mode_o)
  );

  typedef struct {
    int    hw;
    int    md;
    int    lw;
    string req;
  } exp_t;

  exp_t q[$];
  int errs = 0;
  int checks = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  localparam int SB = 0, NM = 1, OV = 2, FB = 3, BU = 4;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: one converter cycle, expected result pushed first
  task automatic run_cyc(int pk, int d, bit lo, bit hi, bit ron,
                         int ehw, int em, int elw, string req);
    exp_t e;
    int n;
    int lc;
    e.hw = ehw; e.md = em; e.lw = elw; e.req = req;
    q.push_back(e);
    low_i  = lo;
    high_i = hi;
    while (!gate_o) @(negedge clk);
    n = 1;
    if (pk == 1) peak_i = 1'b1;
    forever begin
      @(negedge clk);
      if (!gate_o) break;
      n++;
      if (n == pk) peak_i = 1'b1;
      res_edge_i = (ron && n == 3);
    end
    peak_i     = 1'b0;
    res_edge_i = 1'b0;
    lc = 1;
    if (d > 0) begin
      while (lc < d) begin
        @(negedge clk);
        lc++;
      end
      res_edge_i = 1'b1;
      @(negedge clk);
      res_edge_i = 1'b0;
    end
  endtask

  // monitor: measure each gate pulse and rest, compare with the queue
  initial begin
    int hw = 0, lw = 0, hw_done = 0, md_fall = 0;
    bit prev = 1'b0, have_fall = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        if (gate_o) begin
          if (!prev) begin
            if (have_fall && q.size() != 0) begin
              e = q.pop_front();
              chk({e.req, " on-width"}, hw_done, e.hw);
              chk({e.req, " mode"}, md_fall, e.md);
              chk({e.req, " rest-width"}, lw, e.lw);
            end
            hw = 0;
          end
          hw++;
        end else begin
          if (prev) begin
            hw_done   = hw;
            md_fall   = int'(mode_o);
            have_fall = 1'b1;
            lw        = 0;
          end
          lw++;
        end
      end
      prev = gate_o;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int w;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset gate", int'(gate_o), 0);
    chk("R1 reset mode", int'(mode_o), SB);
    mon_en = 1'b1;
    en_i   = 1'b1;
    // initial measurement 64 -> 48, then 40 -> 30, 43 -> 32
    run_cyc(0, 40, 0, 0, 0, 48, NM, 40, "R1 R5");
    run_cyc(0, 43, 0, 0, 0, 30, NM, 43, "R3");
    run_cyc(0, 40, 0, 1, 0, 32, OV, 40, "R4");
    run_cyc(20, 40, 0, 1, 0, 20, OV, 40, "R8 long cut");
    run_cyc(8, 40, 0, 1, 0, 8, FB, 60, "R8 short cut");
    run_cyc(0, 40, 0, 1, 0, 15, FB, 60, "R9");
    run_cyc(0, 40, 0, 1, 0, 15, FB, 60, "R9");
    run_cyc(0, 40, 0, 1, 0, 15, FB, 60, "R9");
    run_cyc(0, 40, 0, 1, 0, 15, BU, 40, "R9 exit");
    run_cyc(0, 40, 0, 1, 0, 30, BU, 40, "R10");
    run_cyc(0, 40, 0, 1, 0, 30, BU, 40, "R10");
    run_cyc(0, 40, 0, 1, 0, 30, FB, 60, "R10 heavy");
    for (int i = 0; i < 3; i++) run_cyc(0, 40, 0, 1, 0, 15, FB, 60, "R9");
    run_cyc(0, 40, 0, 1, 0, 15, BU, 40, "R9 exit");
    run_cyc(0, 40, 0, 0, 0, 30, BU, 40, "R10");
    run_cyc(0, 40, 0, 0, 0, 30, BU, 40, "R10");
    run_cyc(0, 40, 0, 0, 0, 30, NM, 40, "R10 light");
    run_cyc(0, 40, 1, 0, 0, 30, SB, 40, "R4 low");
    run_cyc(0, 40, 1, 0, 0, 30, SB, 40, "R6 lvl0");
    run_cyc(0, 40, 1, 0, 0, 15, SB, 40, "R6 lvl1");
    run_cyc(0, 40, 1, 0, 0, 7, SB, 48, "R6 lvl2");
    run_cyc(0, 40, 1, 0, 0, 7, SB, 56, "R6 lvl3");
    run_cyc(0, 40, 1, 0, 0, 7, SB, 56, "R5 saturate");
    run_cyc(0, 40, 0, 0, 0, 7, SB, 48, "R5 down");
    run_cyc(0, 40, 0, 0, 0, 7, SB, 40, "R5 down");
    run_cyc(0, 40, 0, 0, 0, 7, SB, 40, "R5 down");
    run_cyc(0, 40, 0, 0, 0, 15, SB, 40, "R5 down");
    run_cyc(5, 40, 0, 0, 0, 30, NM, 40, "R7 standby peak");
    run_cyc(0, 0, 0, 0, 0, 30, NM, 200, "R2 timeout");
    run_cyc(5, 40, 0, 0, 1, 150, NM, 40, "R2 R7 normal");
    while (q.size() != 0) @(negedge clk);
    mon_en = 1'b0;
    chk("R4 mode before init", int'(mode_o), NM);
    init_i = 1'b1;
    @(negedge clk);
    init_i = 1'b0;
    chk("R11 init mode", int'(mode_o), SB);
    repeat (300) begin
      @(negedge clk);
      if (gate_o) break;
    end
    chk("R11 switching continues", int'(gate_o), 1);
    en_i = 1'b0;
    @(negedge clk);
    chk("R1 gate off", int'(gate_o), 0);
    chk("R1 mode standby", int'(mode_o), SB);
    repeat (3) @(negedge clk);
    en_i = 1'b1;
    while (!gate_o) @(negedge clk);
    w = 0;
    while (gate_o) begin
      w++;
      @(negedge clk);
    end
    chk("R1 first width after enable", w, 48);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule